// File: doc/BRIEF.md
# Mode-Banked Register File

This block stores the 32-bit working registers of a processor that runs in six operating modes. A logical register index of 4 bits is turned into a physical slot. The mapping depends on a 5-bit mode code that comes with each access. Some indices are shared by every mode. Others have a private copy in certain exception modes, so a handler can use its own stack pointer and link register, and in fast-interrupt mode its own upper working registers, without saving the interrupted context first.

There are two combinational read ports and one write port, which writes on the clock edge. Each port carries its own index and mode code, so a core can read with one mode while writing with another. The block also holds one saved-status register for each exception mode, with its own read and write access, and the single current-status register. The block only maps indices to storage and stores the data. Program-counter arithmetic, flag logic and mode sequencing are left to the surrounding core.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears all 37 physical registers to zero. These are 31 general slots, the current-status register and five saved-status registers.
- R2: Mode codes decode as follows: 10000 user, 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined. Every other 5-bit code behaves as user mode.
- R3: Indices 0–7 and index 15 (program counter) name the same physical register in every mode.
- R4: In fast-interrupt mode, indices 8–14 each name a private register that user mode and the other modes cannot reach.
- R5: Interrupt, supervisor, abort and undefined mode each have private copies of indices 13 and 14. Their indices 8–12 name the user copies.
- R6: Both read ports return, with no clock delay, the register chosen by their own index and mode, independently of each other.
- R7: When `wr_en` is high at a rising edge, `wr_data` is stored in the register selected by `wr_idx` and `wr_mode`. A read of that register is valid after the edge.
- R8: When a read and a write address the same physical register in one cycle, the read returns the value held before the edge. No write data is forwarded.
- R9: Each exception mode has its own saved-status register. It is written through `sav_wr_*` at the clock edge and read combinationally through `sav_rd_mode`.
- R10: A saved-status read with a user-mode code (including any unlisted code) returns zero. A saved-status write with such a code changes nothing.
- R11: The current-status register is loaded from `cst_wr_data` when `cst_wr_en` is high at a rising edge, and is always visible on `cst_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rda_idx | input | 4 | Read port A logical index |
| rda_mode | input | 5 | Read port A mode code |
| rda_data | output | 32 | Read port A data |
| rdb_idx | input | 4 | Read port B logical index |
| rdb_mode | input | 5 | Read port B mode code |
| rdb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write logical index |
| wr_mode | input | 5 | Write mode code |
| wr_data | input | 32 | Write data |
| sav_rd_mode | input | 5 | Mode whose saved status is read |
| sav_rd_data | output | 32 | Saved-status read data |
| sav_wr_en | input | 1 | Saved-status write enable |
| sav_wr_mode | input | 5 | Mode whose saved status is written |
| sav_wr_data | input | 32 | Saved-status write data |
| cst_wr_en | input | 1 | Current-status write enable |
| cst_wr_data | input | 32 | Current-status write data |
| cst_data | output | 32 | Current-status value |

## Verification
The read ports and the saved-status read respond in the same cycle as their address and mode inputs. Writes and reset show up only after the next rising edge. The bench changes every input on the falling edge. It samples combinational reads 1 ns after it drives them, and samples write results on the falling edge that follows the writing edge. For the read-during-write case it samples before the edge, to see the old value, and again on the next falling edge, to see the new one. A bench-side model computes the physical slot for each mode and index on its own and sweeps all six modes, three unlisted codes and all sixteen indices.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    rda_idx,
  input  logic [4:0]    rda_mode,
  output logic [DW-1:0] rda_data,
  input  logic [3:0]    rdb_idx,
  input  logic [4:0]    rdb_mode,
  output logic [DW-1:0] rdb_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [4:0]    wr_mode,
  input  logic [DW-1:0] wr_data,
  input  logic [4:0]    sav_rd_mode,
  output logic [DW-1:0] sav_rd_data,
  input  logic          sav_wr_en,
  input  logic [4:0]    sav_wr_mode,
  input  logic [DW-1:0] sav_wr_data,
  input  logic          cst_wr_en,
  input  logic [DW-1:0] cst_wr_data,
  output logic [DW-1:0] cst_data
);
  localparam int NGP  = 31;
  localparam int NSAV = 5;

  logic [DW-1:0] gp  [NGP];
  logic [DW-1:0] sav [NSAV];
  logic [DW-1:0] cst;

  // bank: 0 user, 1 fast irq, 2 irq, 3 supervisor, 4 abort, 5 undefined
  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      5'b10001: bank_of = 3'd1;
      5'b10010: bank_of = 3'd2;
      5'b10011: bank_of = 3'd3;
      5'b10111: bank_of = 3'd4;
      5'b11011: bank_of = 3'd5;
      default:  bank_of = 3'd0;
    endcase
  endfunction

  // slots 0..15 shared, 16..22 fast-irq 8..14, 23..30 pairs of 13/14
  function automatic logic [4:0] slot_of(input logic [3:0] i, input logic [2:0] b);
    if (b == 3'd1 && i >= 4'd8 && i <= 4'd14)
      slot_of = 5'd16 + {1'b0, i} - 5'd8;
    else if (b >= 3'd2 && (i == 4'd13 || i == 4'd14))
      slot_of = 5'd23 + {1'b0, b - 3'd2, 1'b0} + {4'd0, i[1]};
    else
      slot_of = {1'b0, i};
  endfunction

  logic [4:0] a_slot, b_slot, w_slot;
  logic [2:0] sr_bank, sw_bank;

  assign a_slot  = slot_of(rda_idx, bank_of(rda_mode));
  assign b_slot  = slot_of(rdb_idx, bank_of(rdb_mode));
  assign w_slot  = slot_of(wr_idx,  bank_of(wr_mode));
  assign sr_bank = bank_of(sav_rd_mode);
  assign sw_bank = bank_of(sav_wr_mode);

  assign rda_data    = gp[a_slot];
  assign rdb_data    = gp[b_slot];
  assign sav_rd_data = (sr_bank == 3'd0) ? '0 : sav[sr_bank - 3'd1];
  assign cst_data    = cst;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NGP; k++) gp[k] <= '0;
      for (int k = 0; k < NSAV; k++) sav[k] <= '0;
      cst <= '0;
    end else begin
      if (wr_en) gp[w_slot] <= wr_data;
      if (sav_wr_en && sw_bank != 3'd0) sav[sw_bank - 3'd1] <= sav_wr_data;
      if (cst_wr_en) cst <= cst_wr_data;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (rda_data == '0 && rdb_data == '0 && sav_rd_data == '0 && cst_data == '0)); // R1

  AST_PC_SHARED: assert property (@(posedge clk) disable iff (rst)
    (rda_idx == 4'd15 && rdb_idx == 4'd15) |-> rda_data == rdb_data); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (a_slot != $past(w_slot) || rda_data == $past(wr_data))); // R7

  AST_USER_SAV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sr_bank == 3'd0) |-> sav_rd_data == '0); // R10

  AST_CST_LOAD: assert property (@(posedge clk) disable iff (rst)
    cst_wr_en |=> cst_data == $past(cst_wr_data)); // R11

  AST_CST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cst_wr_en |=> $stable(cst_data)); // R11
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst;
  logic [3:0] rda_idx, rdb_idx, wr_idx;
  logic [4:0] rda_mode, rdb_mode, wr_mode, sav_rd_mode, sav_wr_mode;
  logic [31:0] rda_data, rdb_data, wr_data, sav_rd_data, sav_wr_data, cst_wr_data, cst_data;
  logic wr_en, sav_wr_en, cst_wr_en;

  banked_regfile uut (.*);

  int checks = 0, failures = 0;
  logic done = 0;
  logic [31:0] model [31];
  logic [31:0] smodel [5];
  logic [4:0] codes [6] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011};
  logic [4:0] odd [3] = '{5'b00000, 5'b11111, 5'b10110};

  function automatic int bslot(int b, int i);
    if (i < 8 || i == 15) return i;
    if (b == 1) return 16 + (i - 8);
    if (b >= 2 && i >= 13) return 23 + 2 * (b - 2) + (i - 13);
    return i;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; sav_wr_en = 0; cst_wr_en = 0;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1; idle();
    rda_idx = 0; rdb_idx = 0; wr_idx = 0; rda_mode = 5'b10000; rdb_mode = 5'b10000;
    wr_mode = 5'b10000; wr_data = 0; sav_rd_mode = 5'b10000; sav_wr_mode = 5'b10000;
    sav_wr_data = 0; cst_wr_data = 0;
    // dirty state before reset
    @(negedge clk); rst = 0; wr_en = 1; wr_idx = 9; wr_mode = 5'b10001; wr_data = 32'hDEAD;
    cst_wr_en = 1; cst_wr_data = 32'hBEEF; sav_wr_en = 1; sav_wr_mode = 5'b10011; sav_wr_data = 32'h77;
    @(negedge clk); idle(); rst = 1;
    @(negedge clk); rst = 0;
    // R1: everything zero
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 16; i++) begin
        rda_mode = codes[b]; rda_idx = i[3:0]; rdb_mode = codes[b]; rdb_idx = i[3:0]; #1;
        chk("R1 gp", rda_data, 0);
        chk("R1 gp portB", rdb_data, 0);
      end
    for (int b = 1; b < 6; b++) begin sav_rd_mode = codes[b]; #1; chk("R1 sav", sav_rd_data, 0); end
    chk("R1 cst", cst_data, 0);
    for (int k = 0; k < 31; k++) model[k] = 0;
    for (int k = 0; k < 5; k++) smodel[k] = 0;

    // R7 write sweep in every mode
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        wr_en = 1; wr_mode = codes[b]; wr_idx = i[3:0];
        wr_data = 32'h5A000000 ^ (b << 12) ^ (i << 4) ^ (b * 16 + i) * 32'h10001;
        model[bslot(b, i)] = wr_data;
        @(negedge clk); idle();
        rda_mode = codes[b]; rda_idx = i[3:0]; #1;
        chk("R7 write visible", rda_data, model[bslot(b, i)]);
      end

    // R2 R3 R4 R5 R6 full read sweep, ports crossed
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 16; i++) begin
        rda_mode = codes[b]; rda_idx = i[3:0];
        rdb_mode = codes[5 - b]; rdb_idx = 4'(15 - i); #1;
        if (i < 8 || i == 15) chk("R3 shared", rda_data, model[i]);
        else if (b == 1) chk("R4 fiq bank", rda_data, model[bslot(b, i)]);
        else chk("R5 bank", rda_data, model[bslot(b, i)]);
        chk("R6 port B", rdb_data, model[bslot(5 - b, 15 - i)]);
      end
    for (int u = 0; u < 3; u++)
      for (int i = 0; i < 16; i++) begin
        rda_mode = odd[u]; rda_idx = i[3:0]; #1;
        chk("R2 unlisted=user", rda_data, model[i]);
      end

    // R8 read during write returns old value
    @(negedge clk);
    rda_mode = 5'b10001; rda_idx = 3; rdb_mode = 5'b10011; rdb_idx = 14;
    wr_en = 1; wr_mode = 5'b10000; wr_idx = 3; wr_data = 32'hCAFE0003; #1;
    chk("R8 old value", rda_data, model[3]);
    @(negedge clk); idle(); model[3] = 32'hCAFE0003;
    chk("R8 new after edge", rda_data, model[3]);
    chk("R5 svc lr untouched", rdb_data, model[bslot(3, 14)]);

    // R9 R10 saved status
    for (int b = 1; b < 6; b++) begin
      @(negedge clk); sav_wr_en = 1; sav_wr_mode = codes[b]; sav_wr_data = 32'h00C0FFEE + b;
      smodel[b - 1] = sav_wr_data;
    end
    @(negedge clk); sav_wr_en = 1; sav_wr_mode = 5'b10000; sav_wr_data = 32'hFFFFFFFF;
    @(negedge clk); sav_wr_mode = 5'b00101;
    @(negedge clk); idle();
    for (int b = 1; b < 6; b++) begin sav_rd_mode = codes[b]; #1; chk("R9 R10 sav", sav_rd_data, smodel[b - 1]); end
    sav_rd_mode = 5'b10000; #1; chk("R10 user sav zero", sav_rd_data, 0);
    sav_rd_mode = 5'b01010; #1; chk("R10 unlisted sav zero", sav_rd_data, 0);

    // R11 current status
    @(negedge clk); cst_wr_en = 1; cst_wr_data = 32'h600000D3;
    @(negedge clk); idle(); chk("R11 cst load", cst_data, 32'h600000D3);
    cst_wr_data = 32'h1; @(negedge clk); chk("R11 cst hold", cst_data, 32'h600000D3);

    // R1 second reset
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    rda_mode = 5'b10001; rda_idx = 12; sav_rd_mode = 5'b11011; #1;
    chk("R1 gp after reset", rda_data, 0);
    chk("R1 sav after reset", sav_rd_data, 0);
    chk("R1 cst after reset", cst_data, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule